// File: doc/BRIEF.md
# Warp Divergence Reconvergence Stack

This block steers control flow for one warp whose lanes run in lockstep. It holds the warp's program counter, an active-lane mask and a stack of saved frames. Each cycle the surrounding pipeline can retire a plain instruction, which moves the PC forward by one. It can instead retire a branch, giving a per-lane condition vector, a taken target and the PC where the two paths meet again. When only some active lanes take the branch, the block parks a merge frame and a frame for the pending fall-through path. It then runs the taken lanes first.

While a frame is saved, the block watches for the running path reaching its meeting PC. On that cycle it raises `hold` and pops one frame. The pipeline's inputs are ignored on that cycle. A frame marked pending starts the deferred path with its own lanes. A merge frame brings back the mask from before the branch. Nested divergence unwinds in last-in, first-out order. A divergent branch that finds fewer than two free slots is dropped, and a sticky flag is raised.

Top module: `simt_reconv_stack`

## Requirements
- R1: After synchronous reset the PC is 0, the active mask is all ones, the stack depth is 0, `overflow` is 0 and `hold` is 0.
- R2: With `hold` low, `adv_valid` high and `br_valid` low, the PC rises by one on the next edge, and the mask and depth stay as they were.
- R3: A branch is uniform when condition AND mask is zero or equals the mask. If no active lane takes it, the PC becomes PC+1. If all active lanes take it, the PC becomes the target. In both cases the mask and depth stay unchanged.
- R4: A divergent branch with room on the stack moves the PC to the target and sets the mask to condition AND mask. It raises the depth by two.
- R5: When the depth is nonzero and the PC equals the meeting PC of the running path, `hold` is high. If the top frame is a pending path, the next edge loads the branch's PC+1 and the lanes that did not take the branch, and lowers the depth by one.
- R6: When the top frame popped under `hold` is a merge frame, the PC stays at the meeting PC and the pre-branch mask returns. The depth drops by one.
- R7: While `hold` is high, `br_valid` and `adv_valid` have no effect on the PC, the mask or the stack.
- R8: A divergent branch arriving when fewer than two slots are free leaves PC, mask and depth unchanged. It sets `overflow`, which then stays high until reset.
- R9: The active mask is never all zeros. Each new path mask is a subset of the mask before the branch.
- R10: With no valid input and `hold` low, all state holds.
- R11: Nested divergences unwind innermost first. After full unwinding the mask equals the one held before the outermost split.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_valid | input | 1 | A non-branch instruction retired |
| br_valid | input | 1 | A branch retired (wins over adv_valid) |
| br_cond | input | LANES | Per-lane branch condition |
| br_target | input | PC_W | Taken-path PC |
| br_reconv | input | PC_W | PC where both paths meet again |
| pc | output | PC_W | Current warp PC |
| active_mask | output | LANES | Lanes enabled for the current instruction |
| hold | output | 1 | A frame pops this cycle; inputs are ignored |
| depth | output | $clog2(DEPTH+1) | Number of saved frames |
| overflow | output | 1 | Sticky: a divergent branch found the stack full |

## Verification
The bench first targets the uniform cases: all active lanes taken and no lane taken. A design that pushed on those would grow the depth and later stall on a meeting PC nobody waits for. It then drives branches while `hold` is high. A design that let them through would jump or push mid-pop and lose the pending path. Nested splits are driven until the stack fills. A design that half-pushed there, or cleared the flag later, would corrupt the unwinding order or report a transient overflow. Random branches with bounded meeting points check that every deferred path runs with exactly the complementary lanes, and that the merge brings back the full earlier mask.

// File: rtl/simt_pkg.sv
package simt_pkg;

    localparam int DEF_LANES = 32;
    localparam int DEF_PC_W  = 16;
    localparam int DEF_DEPTH = 8;

    typedef enum logic [1:0] {
        BR_NONE_TAKEN = 2'd0,
        BR_ALL_TAKEN  = 2'd1,
        BR_SPLIT      = 2'd2
    } br_kind_e;

    // Classify a branch from the two lane subsets.
    function automatic br_kind_e classify(input logic any_taken, input logic any_fall);
        if (!any_taken)     return BR_NONE_TAKEN;
        else if (!any_fall) return BR_ALL_TAKEN;
        else                return BR_SPLIT;
    endfunction

endpackage

// File: rtl/simt_lane_split.sv
module simt_lane_split
    import simt_pkg::*;
#(
    parameter int LANES = DEF_LANES
) (
    input  logic [LANES-1:0] cond,
    input  logic [LANES-1:0] mask,
    output logic [LANES-1:0] taken,
    output logic [LANES-1:0] fall,
    output br_kind_e         kind
);
    always_comb begin
        taken = cond & mask;
        fall  = ~cond & mask;
        kind  = classify(|taken, |fall);
    end
endmodule

// File: rtl/simt_entry_stack.sv
module simt_entry_stack #(
    parameter int DEPTH = 8,
    parameter int EW    = 8,
    localparam int DW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push2,
    input  logic          pop,
    input  logic [EW-1:0] lo_in,
    input  logic [EW-1:0] hi_in,
    output logic [EW-1:0] top_out,
    output logic [DW-1:0] depth,
    output logic          room2
);
    logic [DW-1:0] depth_q;
    logic [EW-1:0] slot_q [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    slot_q[i] <= '0;
                end else if (push2 && int'(depth_q) == i) begin
                    slot_q[i] <= lo_in;
                end else if (push2 && int'(depth_q) + 1 == i) begin
                    slot_q[i] <= hi_in;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)        depth_q <= '0;
        else if (push2) depth_q <= depth_q + DW'(2);
        else if (pop)   depth_q <= depth_q - DW'(1);
    end

    always_comb begin
        top_out = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (int'(depth_q) == i + 1) top_out = slot_q[i];
        end
    end

    assign depth = depth_q;
    assign room2 = (int'(depth_q) + 2) <= DEPTH;
endmodule

// File: rtl/simt_flow_sel.sv
module simt_flow_sel
    import simt_pkg::*;
#(
    parameter int LANES = DEF_LANES,
    parameter int PC_W  = DEF_PC_W
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [LANES-1:0] mask,
    input  logic [PC_W-1:0]  rpc,
    input  logic             stack_nz,
    input  logic             room2,
    input  logic             top_pending,
    input  logic [PC_W-1:0]  top_pc,
    input  logic [LANES-1:0] top_mask,
    input  logic [PC_W-1:0]  top_rpc,
    input  logic             adv_valid,
    input  logic             br_valid,
    input  br_kind_e         kind,
    input  logic [LANES-1:0] taken,
    input  logic [PC_W-1:0]  target,
    input  logic [PC_W-1:0]  reconv,
    output logic [PC_W-1:0]  nxt_pc,
    output logic [LANES-1:0] nxt_mask,
    output logic [PC_W-1:0]  nxt_rpc,
    output logic             push2,
    output logic             pop,
    output logic             ovf_set,
    output logic             hold
);
    always_comb begin
        hold     = stack_nz && (pc == rpc);
        nxt_pc   = pc;
        nxt_mask = mask;
        nxt_rpc  = rpc;
        push2    = 1'b0;
        pop      = 1'b0;
        ovf_set  = 1'b0;
        if (hold) begin
            pop      = 1'b1;
            nxt_mask = top_mask;
            nxt_rpc  = top_rpc;
            if (top_pending) nxt_pc = top_pc;
        end else if (br_valid) begin
            unique case (kind)
                BR_NONE_TAKEN: nxt_pc = pc + PC_W'(1);
                BR_ALL_TAKEN:  nxt_pc = target;
                default: begin
                    if (room2) begin
                        push2    = 1'b1;
                        nxt_pc   = target;
                        nxt_mask = taken;
                        nxt_rpc  = reconv;
                    end else begin
                        ovf_set  = 1'b1;
                    end
                end
            endcase
        end else if (adv_valid) begin
            nxt_pc = pc + PC_W'(1);
        end
    end
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
    import simt_pkg::*;
#(
    parameter int LANES = DEF_LANES,
    parameter int PC_W  = DEF_PC_W,
    parameter int DEPTH = DEF_DEPTH,
    localparam int DW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv_valid,
    input  logic             br_valid,
    input  logic [LANES-1:0] br_cond,
    input  logic [PC_W-1:0]  br_target,
    input  logic [PC_W-1:0]  br_reconv,
    output logic [PC_W-1:0]  pc,
    output logic [LANES-1:0] active_mask,
    output logic             hold,
    output logic [DW-1:0]    depth,
    output logic             overflow
);
    typedef struct packed {
        logic             pending;
        logic [PC_W-1:0]  resume_pc;
        logic [LANES-1:0] mask;
        logic [PC_W-1:0]  rpc;
    } frame_t;

    localparam int EW = $bits(frame_t);

    logic [PC_W-1:0]  pc_q, rpc_q, nxt_pc, nxt_rpc;
    logic [LANES-1:0] mask_q, nxt_mask, taken, fall;
    logic             ovf_q, push2, pop, ovf_set, room2;
    br_kind_e         kind;
    frame_t           merge_f, path_f, top_f;
    logic [EW-1:0]    top_bits;
    logic [DW-1:0]    depth_w;

    simt_lane_split #(.LANES(LANES)) u_split (
        .cond (br_cond),
        .mask (mask_q),
        .taken(taken),
        .fall (fall),
        .kind (kind)
    );

    always_comb begin
        merge_f.pending   = 1'b0;
        merge_f.resume_pc = br_reconv;
        merge_f.mask      = mask_q;
        merge_f.rpc       = rpc_q;
        path_f.pending    = 1'b1;
        path_f.resume_pc  = pc_q + PC_W'(1);
        path_f.mask       = fall;
        path_f.rpc        = br_reconv;
        top_f             = frame_t'(top_bits);
    end

    simt_entry_stack #(.DEPTH(DEPTH), .EW(EW)) u_stack (
        .clk    (clk),
        .rst    (rst),
        .push2  (push2),
        .pop    (pop),
        .lo_in  (merge_f),
        .hi_in  (path_f),
        .top_out(top_bits),
        .depth  (depth_w),
        .room2  (room2)
    );

    simt_flow_sel #(.LANES(LANES), .PC_W(PC_W)) u_sel (
        .pc         (pc_q),
        .mask       (mask_q),
        .rpc        (rpc_q),
        .stack_nz   (depth_w != '0),
        .room2      (room2),
        .top_pending(top_f.pending),
        .top_pc     (top_f.resume_pc),
        .top_mask   (top_f.mask),
        .top_rpc    (top_f.rpc),
        .adv_valid  (adv_valid),
        .br_valid   (br_valid),
        .kind       (kind),
        .taken      (taken),
        .target     (br_target),
        .reconv     (br_reconv),
        .nxt_pc     (nxt_pc),
        .nxt_mask   (nxt_mask),
        .nxt_rpc    (nxt_rpc),
        .push2      (push2),
        .pop        (pop),
        .ovf_set    (ovf_set),
        .hold       (hold)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            mask_q <= '1;
            rpc_q  <= '0;
            ovf_q  <= 1'b0;
        end else begin
            pc_q   <= nxt_pc;
            mask_q <= nxt_mask;
            rpc_q  <= nxt_rpc;
            if (ovf_set) ovf_q <= 1'b1;
        end
    end

    assign pc          = pc_q;
    assign active_mask = mask_q;
    assign depth       = depth_w;
    assign overflow    = ovf_q;
endmodule

// File: rtl/simt_reconv_stack_chk.sv
module simt_reconv_stack_chk #(
    parameter int LANES = 32,
    parameter int PC_W  = 16,
    parameter int DEPTH = 8,
    localparam int DW   = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             adv_valid,
    input logic             br_valid,
    input logic [LANES-1:0] br_cond,
    input logic [PC_W-1:0]  pc,
    input logic [LANES-1:0] active_mask,
    input logic             hold,
    input logic [DW-1:0]    depth,
    input logic             overflow
);
    AST_MASK_NONZERO: assert property (@(posedge clk) disable iff (rst)
        active_mask != '0); // R9

    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(depth) <= DEPTH); // R8

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow); // R8

    AST_HOLD_POPS: assert property (@(posedge clk) disable iff (rst)
        hold |=> int'(depth) == int'($past(depth)) - 1); // R5

    AST_UNIFORM_NOPUSH: assert property (@(posedge clk) disable iff (rst)
        (!hold && br_valid && ((br_cond & active_mask) == '0))
        |=> (depth == $past(depth)) && (pc == $past(pc) + PC_W'(1))); // R3

    AST_PATH_SUBSET: assert property (@(posedge clk) disable iff (rst)
        (!hold && (br_valid || adv_valid))
        |=> (active_mask & ~$past(active_mask)) == '0); // R9

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!hold && !br_valid && !adv_valid)
        |=> $stable(pc) && $stable(active_mask) && $stable(depth)); // R10
endmodule

bind simt_reconv_stack simt_reconv_stack_chk #(
    .LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .adv_valid  (adv_valid),
    .br_valid   (br_valid),
    .br_cond    (br_cond),
    .pc         (pc),
    .active_mask(active_mask),
    .hold       (hold),
    .depth      (depth),
    .overflow   (overflow)
);

// File: tb/simt_reconv_stack_tb.sv
module simt_reconv_stack_tb;
    localparam int LANES = 32;
    localparam int PC_W  = 16;
    localparam int DEPTH = 8;
    localparam int DW    = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             adv_valid = 1'b0;
    logic             br_valid = 1'b0;
    logic [LANES-1:0] br_cond = '0;
    logic [PC_W-1:0]  br_target = '0;
    logic [PC_W-1:0]  br_reconv = '0;
    logic [PC_W-1:0]  pc;
    logic [LANES-1:0] active_mask;
    logic             hold;
    logic [DW-1:0]    depth;
    logic             overflow;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    simt_reconv_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .adv_valid(adv_valid), .br_valid(br_valid),
        .br_cond(br_cond), .br_target(br_target), .br_reconv(br_reconv),
        .pc(pc), .active_mask(active_mask), .hold(hold), .depth(depth),
        .overflow(overflow)
    );

    // Reference state, written from the requirements.
    logic [PC_W-1:0]  m_pc, m_rpc;
    logic [LANES-1:0] m_mask;
    int               m_depth;
    bit               m_ovf;
    bit               s_pend [DEPTH];
    logic [PC_W-1:0]  s_pc   [DEPTH];
    logic [LANES-1:0] s_mask [DEPTH];
    logic [PC_W-1:0]  s_rpc  [DEPTH];

    function automatic bit m_hold();
        return (m_depth > 0) && (m_pc == m_rpc);
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_pc = '0; m_rpc = '0; m_mask = '1; m_depth = 0; m_ovf = 1'b0;
    endtask

    // Advance the model by one edge; returns the requirement exercised.
    function automatic string model_step(input bit adv, input bit br, input logic [LANES-1:0] c,
                                         input logic [PC_W-1:0] tgt, input logic [PC_W-1:0] rcv);
        logic [LANES-1:0] t, n;
        string tag;
        if (m_hold()) begin
            m_depth--;
            tag = s_pend[m_depth] ? "R5" : "R6";
            if (s_pend[m_depth]) m_pc = s_pc[m_depth];
            m_mask = s_mask[m_depth];
            m_rpc  = s_rpc[m_depth];
            if (adv || br) tag = "R7";
        end else if (br) begin
            t = c & m_mask;
            n = ~c & m_mask;
            if (t == '0) begin
                m_pc = m_pc + 1'b1; tag = "R3";
            end else if (n == '0) begin
                m_pc = tgt; tag = "R3";
            end else if (m_depth > DEPTH - 2) begin
                m_ovf = 1'b1; tag = "R8";
            end else begin
                s_pend[m_depth] = 1'b0; s_pc[m_depth] = rcv;
                s_mask[m_depth] = m_mask; s_rpc[m_depth] = m_rpc;
                s_pend[m_depth+1] = 1'b1; s_pc[m_depth+1] = m_pc + 1'b1;
                s_mask[m_depth+1] = n; s_rpc[m_depth+1] = rcv;
                m_depth += 2;
                m_pc = tgt; m_mask = t; m_rpc = rcv; tag = "R4";
            end
        end else if (adv) begin
            m_pc = m_pc + 1'b1; tag = "R2";
        end else begin
            tag = "R10";
        end
        return tag;
    endfunction

    task automatic compare(input string tag);
        chk(tag, "pc", pc, m_pc);
        chk(tag, "mask", active_mask, m_mask);
        chk(tag, "depth", depth, m_depth);
        chk(tag, "overflow", overflow, m_ovf);
        chk(tag, "hold", hold, m_hold());
        chk("R9", "mask_nonzero", active_mask != '0, 1);
    endtask

    task automatic step(input bit adv, input bit br, input logic [LANES-1:0] c,
                        input logic [PC_W-1:0] tgt, input logic [PC_W-1:0] rcv);
        string tag;
        @(negedge clk);
        adv_valid = adv; br_valid = br; br_cond = c; br_target = tgt; br_reconv = rcv;
        @(posedge clk);
        tag = model_step(adv, br, c, tgt, rcv);
        #1;
        compare(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; adv_valid = 1'b0; br_valid = 1'b0;
        @(posedge clk); @(posedge clk);
        #1;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        chk("R1", "pc", pc, 0);
        chk("R1", "mask", active_mask, 32'hFFFF_FFFF);
        chk("R1", "depth", depth, 0);
        chk("R1", "overflow", overflow, 0);
        chk("R1", "hold", hold, 0);
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        do_reset();

        // Directed: advance, idle, uniform branches.
        step(1, 0, '0, 0, 0);
        chk("R2", "pc_after_adv", pc, 1);
        step(0, 0, '0, 0, 0);
        chk("R10", "pc_idle", pc, 1);
        step(0, 1, '1, 5, 9);
        chk("R3", "all_taken_pc", pc, 5);
        step(0, 1, '0, 3, 9);
        chk("R3", "none_taken_pc", pc, 6);
        // Divergence, pending path, merge, branch ignored under hold.
        step(0, 1, 32'h00FF_00FF, 8, 10);
        chk("R4", "split_mask", active_mask, 32'h00FF_00FF);
        chk("R4", "split_depth", depth, 2);
        step(1, 0, '0, 0, 0);
        step(1, 0, '0, 0, 0);
        chk("R5", "hold_at_reconv", hold, 1);
        step(0, 1, 32'h1, 16'd30, 16'd40);
        chk("R7", "pc_after_held_branch", pc, 7);
        chk("R5", "fall_mask", active_mask, 32'hFF00_FF00);
        for (int i = 0; i < 3; i++) step(1, 0, '0, 0, 0);
        step(0, 0, '0, 0, 0);
        chk("R6", "merge_mask", active_mask, 32'hFFFF_FFFF);
        chk("R6", "merge_pc", pc, 10);

        // Directed: nested splits to full stack, then overflow.
        do_reset();
        step(0, 1, 32'h0000_FFFF, 10, 100);
        step(0, 1, 32'h0000_00FF, 20, 90);
        step(0, 1, 32'h0000_000F, 30, 80);
        step(0, 1, 32'h0000_0003, 40, 70);
        chk("R8", "full_depth", depth, DEPTH);
        step(0, 1, 32'h0000_0001, 50, 60);
        chk("R8", "ovf_set", overflow, 1);
        chk("R8", "pc_unchanged", pc, 40);
        chk("R8", "mask_unchanged", active_mask, 32'h3);
        for (int i = 0; i < 400 && m_depth > 0; i++) step(1, 0, '0, 0, 0);
        chk("R11", "unwound_depth", depth, 0);
        chk("R11", "unwound_mask", active_mask, 32'hFFFF_FFFF);
        chk("R8", "ovf_sticky", overflow, 1);

        // Constrained random.
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            int op;
            logic [LANES-1:0] c;
            logic [PC_W-1:0] rcv, tgt;
            op = $urandom % 10;
            if (op < 4) begin
                step(1, 0, '0, 0, 0);
            end else if (op < 8) begin
                c = $urandom;
                if (op == 4) c = '0;
                if (op == 5) c = '1;
                rcv = m_pc + PC_W'(2 + $urandom % 6);
                if (m_depth > 0 && rcv > m_rpc) rcv = m_rpc;
                if (rcv <= m_pc + 1'b1) begin
                    step(1, 0, '0, 0, 0);
                end else begin
                    tgt = m_pc + PC_W'(1 + $urandom % int'(rcv - m_pc));
                    step(0, 1, c, tgt, rcv);
                end
            end else begin
                step(0, 0, '0, 0, 0);
            end
            if (m_pc > 16'hF000) do_reset();
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule